// File: doc/BRIEF.md
# Asymmetric Attack/Release Debouncer with Hold

A single-channel contact debouncer for an input that is active low. The raw input is compared with the registered output on every debounce tick. The output takes the new level only after four consecutive ticks on which the input differed from it. Any tick on which the input equals the output clears the integration and starts the count again.

The tick rate depends on the current output level, so the leading edge and the trailing edge see different delays. One rate is the full clock rate. The other is the clock divided by a 4-bit ratio input. A mode input picks which edge gets the fast rate: fast attack with slow release, or slow attack with fast release. The divider restarts whenever the slow rate becomes selected, so the first slow tick always comes a full period later.

A hold input stops all ticking once the output has gone low. The output then stays low whatever the raw input does, and it is released through normal debouncing after the hold input is lowered.

Top module: `asym_debounce`

## Requirements
- R1: Reset drives `out_o` high and clears the integration. It also restarts the divider, so with the slow rate selected the first tick comes on the N-th rising edge after reset is released.
- R2: With `mode_i`=0 and `out_o` high, the tick comes on every clock. A low input held steady makes `out_o` fall on the 4th rising edge after the input changed.
- R3: With `mode_i`=0 and `out_o` low, the tick comes every N clocks, counted from the edge where `out_o` fell. An input that goes high just after that edge raises `out_o` on the 4N-th rising edge.
- R4: With `mode_i`=1 the rates swap. A falling output takes 4N edges and a rising output takes 4 edges. In both modes the divider restarts each time the slow rate becomes selected.
- R5: A tick on which `raw_i` equals `out_o` clears the integration. After a one-tick bounce, four more differing ticks are needed.
- R6: A ratio value of 0 behaves exactly like a ratio of 1.
- R7: While `latch_i`=1 and `out_o` is low, no tick occurs. `out_o` stays low for any `raw_i`, and the integrator and divider hold their state.
- R8: While `out_o` is high, `latch_i` has no effect, and the falling delay is the same as when it is 0.
- R9: After `latch_i` returns to 0, ticking resumes from the frozen state. In mode 0, with `raw_i` high, `out_o` rises on the 4N-th edge after the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Raw contact level (low = active) |
| ratio_i | input | DIV_W | Slow-rate divide ratio N (0 treated as 1) |
| mode_i | input | 1 | 0: fast attack / slow release, 1: slow attack / fast release |
| latch_i | input | 1 | Hold the output once it is low |
| out_o | output | 1 | Debounced output |

## Verification
The bench uses the default build: a 4-bit ratio and a four-tick integrator. It sweeps all sixteen ratio values in both modes. Each case measures the exact edge count of the falling transition, the rising transition, and a second falling transition. The expected delays come from 4 and 4N. This covers ratio 0, ratio 1 and the largest ratio, along with the divider restart at each rate switch. Single-tick bounces in both directions and a full hold-and-release sequence are checked edge by edge.

// File: rtl/asym_debounce_pkg.sv
package asym_debounce_pkg;
  typedef enum logic {
    FAST_ATTACK = 1'b0,
    SLOW_ATTACK = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/deb_tick_div.sv
module deb_tick_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, last;
  logic             wrap;

  assign last   = (ratio_i == '0) ? '0 : ratio_i - 1'b1;
  assign wrap   = (cnt_q >= last);
  assign tick_o = run_i && (!slow_i || wrap);

  // counter held at zero on the fast rate: restarts on every switch to slow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!slow_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  a_r3_slow_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i && last != '0 && tick_o |=> !tick_o || !slow_i || !$stable(ratio_i));
  a_r7_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && slow_i |=> $stable(cnt_q));
endmodule

// File: rtl/deb_integ.sv
module deb_integ #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic out_o
);
  localparam int SR_W = DEPTH - 1;

  logic [SR_W-1:0] sr_q, sr_inc;
  logic            out_q, differ;

  assign differ = (raw_i != out_q);
  assign sr_inc = sr_q + 1'b1;
  assign out_o  = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      out_q <= 1'b1;
    end else if (tick_i) begin
      if (!differ) begin
        sr_q <= '0;
      end else if (&sr_q) begin
        sr_q  <= '0;
        out_q <= raw_i;
      end else begin
        sr_q <= {sr_q[SR_W-2:0], 1'b1};
      end
    end
  end

  a_r2_flip_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q != $past(out_q) |-> $past(tick_i));
  a_r5_equal_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !differ |=> sr_q == '0);
  a_r5_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sr_inc));
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sr_q) && $stable(out_q));
endmodule

// File: rtl/asym_debounce.sv
module asym_debounce
  import asym_debounce_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             mode_i,
  input  logic             latch_i,
  output logic             out_o
);
  edge_mode_e mode;
  logic       slow, run, tick, out_w;

  assign mode  = edge_mode_e'(mode_i);
  assign slow  = (mode == FAST_ATTACK) ? !out_w : out_w;
  assign run   = !(latch_i && !out_w);
  assign out_o = out_w;

  deb_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (slow),
    .run_i  (run),
    .ratio_i(ratio_i),
    .tick_o (tick)
  );

  deb_integ #(.DEPTH(DEPTH)) i_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .raw_i (raw_i),
    .out_o (out_w)
  );

  a_r7_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && !out_o |=> !out_o);
  a_r4_fast_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && mode == SLOW_ATTACK && !out_o && raw_i |-> tick);
endmodule

// File: tb/test_asym_debounce.sv
`timescale 1ns/1ps
module test_asym_debounce;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b1;
  logic [3:0] ratio = 4'd1;
  logic       mode = 1'b0;
  logic       latch = 1'b0;
  logic       out;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  asym_debounce i_asym_debounce (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .ratio_i(ratio),
    .mode_i(mode), .latch_i(latch), .out_o(out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d ratio %0d)", req, act, exp, mode, ratio);
    end
  endtask

  task automatic do_reset(input logic m, input logic [3:0] n);
    @(negedge clk);
    rst_n = 1'b0; raw = 1'b1; latch = 1'b0; mode = m; ratio = n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset output", int'(out), 1);
  endtask

  // counts rising edges from the stimulus until out changes
  task automatic measure(input bit wait_neg, input logic nraw, input logic nlatch, output int k);
    logic old;
    if (wait_neg) @(negedge clk);
    old = out; raw = nraw; latch = nlatch; k = 0;
    while (k < 300) begin
      @(posedge clk); #1; k++;
      if (out != old) break;
    end
  endtask

  initial begin
    int k, e, stuck;
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 16; n++) begin
        e = (n == 0) ? 1 : n;
        do_reset(m[0], n[3:0]);
        if (m == 0) begin
          measure(1, 1'b0, 1'b0, k); check(n == 0 ? "R2 R6 attack" : "R2 attack", k, 4);
          measure(1, 1'b1, 1'b0, k); check(n == 0 ? "R3 R6 release" : "R3 release", k, 4 * e);
          measure(1, 1'b0, 1'b0, k); check("R2 second attack", k, 4);
        end else begin
          measure(0, 1'b0, 1'b0, k); check(n == 0 ? "R1 R4 R6 attack from reset" : "R1 R4 attack from reset", k, 4 * e);
          measure(1, 1'b1, 1'b0, k); check("R4 fast release", k, 4);
          measure(1, 1'b0, 1'b0, k); check("R4 restart slow attack", k, 4 * e);
        end
      end
    end

    // R5 bounce during fast attack
    do_reset(1'b0, 4'd1);
    @(negedge clk); raw = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R5 no flip before 4 ticks", int'(out), 1);
    @(negedge clk); raw = 1'b1;
    @(posedge clk);
    measure(1, 1'b0, 1'b0, k); check("R5 bounce restarts attack", k, 4);

    // R5 bounce during fast release in mode 1
    do_reset(1'b1, 4'd1);
    measure(0, 1'b0, 1'b0, k); check("R4 attack ratio 1", k, 4);
    @(negedge clk); raw = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R5 no release before 4 ticks", int'(out), 0);
    @(negedge clk); raw = 1'b0;
    @(posedge clk);
    measure(1, 1'b1, 1'b0, k); check("R5 bounce restarts release", k, 4);

    // R7 R8 R9 hold sequence
    do_reset(1'b0, 4'd3);
    measure(1, 1'b0, 1'b1, k); check("R8 attack with latch high", k, 4);
    @(negedge clk); raw = 1'b1;
    stuck = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (out != 1'b0) stuck++;
    end
    check("R7 output held low", stuck, 0);
    measure(1, 1'b1, 1'b0, k); check("R9 release after unlatch", k, 12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule